// File: doc/BRIEF.md
# Packet Memory Data Port

This block is the host's word-wide window into a local packet store split into a transmit area and a receive area. The host first writes a pointer word that picks the area, the transfer direction, whether the offset steps forward after each access, and a starting byte offset. It then moves 16-bit words through one data register. Host writes pass through a small write FIFO that drains into memory one word per cycle. Host reads are served from a prefetched word, so each data read returns its word on the next cycle.

For transmit, the host streams the frame bytes into the buffer starting at byte offset 4 and then issues a seal command that carries the frame length. The block then finishes the buffer itself. It writes a zero status word, writes a byte count that covers the padded frame plus six bytes of overhead, and rewrites the word just past the data as the trailing control word. For receive, the block watches the host read the first two words of the receive area and presents the status word, an error verdict and the payload byte count on output ports.

Top module: `pkt_data_port`

## Requirements
- R1: After a synchronous reset, a pointer read returns 0x0000, reg_rdata is 0, and rx_status, rx_payload_len and rx_bad are 0.
- R2: Pointer word layout: bit 15 selects read direction, bit 14 selects the receive area, bit 13 enables auto-increment, bit 12 reads back 1 while a seal is in progress, bit 11 reads back 1 while the write FIFO holds data, and bits 10:0 are the byte offset. Bit 0 of a written offset is forced to 0. Bits 12 and 11 are read-only.
- R3: With auto-increment set, every data write (as it drains) and every data read advances the offset by 2. With auto-increment clear, the offset does not move.
- R4: A pointer write made while the write FIFO holds data, or while a seal is in progress, is ignored. The not-empty flag (bit 11) is 1 on the cycle after a data write that has not yet drained.
- R5: After a pointer write that selects read direction and one idle cycle, each data read returns the word at the current offset on the following cycle. This also holds for back-to-back reads.
- R6: A seal command (select 2, written data bits 10:0 = frame length L) stores 0x0000 at transmit byte offset 0 and the padded length plus 6 at byte offset 2.
- R7: A frame length below 60 is taken as 60 before the byte count and the control word position are computed.
- R8: The control word sits at transmit byte offset 4 + (padded length rounded down to even). For an odd padded length it holds 0x2000 OR the low byte of the host word already at that position. For an even padded length it is written as 0x0000.
- R9: When the host reads receive byte offset 0 in read mode, rx_status takes that word, and rx_bad is 1 exactly when the word has any bit set that is also set in ERR_MASK (default 0xAC00).
- R10: When the host reads receive byte offset 2 in read mode, rx_payload_len takes the low 11 bits of that word minus 4. The upper 5 bits are ignored.
- R11: A data write made while the pointer selects read direction is discarded and leaves memory unchanged.
- R12: Bit 12 of the pointer reads 1 on the cycle after an accepted seal command and returns to 0 once the seal sequence has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 pointer, 1 data, 2 seal |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_rd | input | 1 | Read strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data, valid the cycle after a read strobe |
| rx_status | output | 16 | Receive status word as last read by the host |
| rx_payload_len | output | 11 | Receive payload byte count (header excluded) |
| rx_bad | output | 1 | Receive status carries an error bit |

## Verification
The bench builds the block with AREA_BYTES = 256 and FIFO_DEPTH = 2. The small area keeps the store at 256 words, so byte offsets fit in eight bits and a sealed frame's control word sits near the end of an area that is easy to read back. The two-entry FIFO stays occupied during a back-to-back write burst. That puts the pointer lock and the not-empty flag within reach of single-cycle stimulus, and it makes the seal wait for the last queued word before it reads the trailing word.

// File: rtl/pdp_pkg.sv
package pdp_pkg;

  localparam logic [1:0] SEL_PTR  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_SEAL = 2'd2;

  localparam int PTR_RD_BIT   = 15;
  localparam int PTR_RX_BIT   = 14;
  localparam int PTR_AI_BIT   = 13;
  localparam int OFF_FIELD_W  = 11;

  localparam logic [15:0] CTL_ODD_FLAG = 16'h2000;
  localparam logic [10:0] MIN_FRAME    = 11'd60;
  localparam logic [15:0] TX_OVERHEAD  = 16'd6;
  localparam logic [10:0] RX_HDR_BYTES = 11'd4;

  typedef struct packed {
    logic rd;
    logic rx;
    logic ainc;
  } ptr_mode_t;

  typedef enum logic [2:0] {
    SL_IDLE,
    SL_WAIT,
    SL_HDR0,
    SL_HDR1,
    SL_RDT,
    SL_CTL
  } seal_st_e;

endpackage

// File: rtl/pdp_ram.sv
module pdp_ram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/pdp_wfifo.sv
module pdp_wfifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] slots [0:DEPTH-1];
  logic [PW-1:0] wr_idx, rd_idx;
  logic [PW:0]   cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == (PW+1)'(DEPTH));
  assign dout  = slots[rd_idx];

  function automatic logic [PW-1:0] step(input logic [PW-1:0] idx);
    return (idx == PW'(DEPTH-1)) ? '0 : idx + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !full) slots[wr_idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      cnt    <= '0;
    end else begin
      if (push && !full) wr_idx <= step(wr_idx);
      if (pop && !empty) rd_idx <= step(rd_idx);
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/pdp_sealer.sv
module pdp_sealer import pdp_pkg::*; #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [10:0]   len_i,
  input  logic          fifo_empty_i,
  input  logic [7:0]    low_byte_i,
  output logic          busy_o,
  output logic          active_o,
  output logic          we_o,
  output logic          re_o,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   wdata_o
);

  seal_st_e    st_q;
  logic [10:0] lp_q;
  logic [AW-2:0] ctl_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SL_IDLE;
      lp_q <= '0;
    end else begin
      case (st_q)
        SL_IDLE: if (start_i) begin
          lp_q <= (len_i < MIN_FRAME) ? MIN_FRAME : len_i;
          st_q <= SL_WAIT;
        end
        SL_WAIT: if (fifo_empty_i) st_q <= SL_HDR0;
        SL_HDR0: st_q <= SL_HDR1;
        SL_HDR1: st_q <= SL_RDT;
        SL_RDT:  st_q <= SL_CTL;
        SL_CTL:  st_q <= SL_IDLE;
        default: st_q <= SL_IDLE;
      endcase
    end
  end

  // control word follows the data; for odd length it shares the last data word
  assign ctl_w    = (AW-1)'(lp_q[10:1]) + (AW-1)'(2);
  assign busy_o   = (st_q != SL_IDLE);
  assign active_o = (st_q == SL_HDR0) || (st_q == SL_HDR1) ||
                    (st_q == SL_RDT)  || (st_q == SL_CTL);

  always_comb begin
    we_o    = 1'b0;
    re_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    case (st_q)
      SL_HDR0: begin
        we_o   = 1'b1;
        addr_o = '0;
      end
      SL_HDR1: begin
        we_o    = 1'b1;
        addr_o  = AW'(1);
        wdata_o = {5'd0, lp_q} + TX_OVERHEAD;
      end
      SL_RDT: begin
        re_o   = 1'b1;
        addr_o = {1'b0, ctl_w};
      end
      SL_CTL: begin
        we_o    = 1'b1;
        addr_o  = {1'b0, ctl_w};
        wdata_o = lp_q[0] ? (CTL_ODD_FLAG | {8'd0, low_byte_i}) : 16'd0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port import pdp_pkg::*; #(
  parameter int          AREA_BYTES = 2048,
  parameter int          FIFO_DEPTH = 4,
  parameter logic [15:0] ERR_MASK   = 16'hAC00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic [15:0] rx_status,
  output logic [10:0] rx_payload_len,
  output logic        rx_bad
);

  localparam int OFF_W = $clog2(AREA_BYTES);
  localparam int AW    = OFF_W;

  ptr_mode_t        mode_q;
  logic [OFF_W-1:0] off_q, off_step;
  logic             pf_req_q;

  logic ptr_wr, data_wr, seal_wr, data_rd, ptr_rd;
  logic ptr_ok, push, drain, rd_fetch, seal_start;
  logic fifo_empty, fifo_full;
  logic [15:0] fifo_dout;

  logic          seal_busy, seal_active, seal_we, seal_re;
  logic [AW-1:0] seal_addr;
  logic [15:0]   seal_wdata;

  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata, mem_q;

  logic unused_ro_bits;
  assign unused_ro_bits = ^reg_wdata[12:11];

  assign ptr_wr  = reg_wr && (reg_sel == SEL_PTR);
  assign data_wr = reg_wr && (reg_sel == SEL_DATA);
  assign seal_wr = reg_wr && (reg_sel == SEL_SEAL);
  assign ptr_rd  = reg_rd && (reg_sel == SEL_PTR);
  assign data_rd = reg_rd && (reg_sel == SEL_DATA);

  assign ptr_ok     = ptr_wr && fifo_empty && !seal_busy;
  assign push       = data_wr && !mode_q.rd && !fifo_full;
  assign seal_start = seal_wr && !mode_q.rd && !seal_busy;
  assign drain      = !fifo_empty && !seal_active;
  assign rd_fetch   = mode_q.rd && (pf_req_q || (data_rd && mode_q.ainc));
  assign off_step   = off_q + OFF_W'(2);

  pdp_wfifo #(.DEPTH(FIFO_DEPTH), .DW(16)) u_wfifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   (reg_wdata),
    .pop   (drain),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  pdp_sealer #(.AW(AW)) u_sealer (
    .clk          (clk),
    .rst          (rst),
    .start_i      (seal_start),
    .len_i        (reg_wdata[10:0]),
    .fifo_empty_i (fifo_empty),
    .low_byte_i   (mem_q[7:0]),
    .busy_o       (seal_busy),
    .active_o     (seal_active),
    .we_o         (seal_we),
    .re_o         (seal_re),
    .addr_o       (seal_addr),
    .wdata_o      (seal_wdata)
  );

  // single memory port: seal sequence, then FIFO drain, then read prefetch
  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (seal_active) begin
      mem_we    = seal_we;
      mem_re    = seal_re;
      mem_addr  = seal_addr;
      mem_wdata = seal_wdata;
    end else if (drain) begin
      mem_we    = 1'b1;
      mem_addr  = {mode_q.rx, off_q[OFF_W-1:1]};
      mem_wdata = fifo_dout;
    end else if (rd_fetch) begin
      mem_re   = 1'b1;
      mem_addr = pf_req_q ? {mode_q.rx, off_q[OFF_W-1:1]}
                          : {mode_q.rx, off_step[OFF_W-1:1]};
    end
  end

  pdp_ram #(.AW(AW), .DW(16)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      off_q    <= '0;
      pf_req_q <= 1'b0;
    end else begin
      pf_req_q <= ptr_ok && reg_wdata[PTR_RD_BIT];
      if (ptr_ok) begin
        mode_q.rd   <= reg_wdata[PTR_RD_BIT];
        mode_q.rx   <= reg_wdata[PTR_RX_BIT];
        mode_q.ainc <= reg_wdata[PTR_AI_BIT];
        off_q       <= {reg_wdata[OFF_W-1:1], 1'b0};
      end else if (drain && mode_q.ainc) begin
        off_q <= off_step;
      end else if (data_rd && mode_q.rd && mode_q.ainc) begin
        off_q <= off_step;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (ptr_rd) begin
      reg_rdata <= {mode_q.rd, mode_q.rx, mode_q.ainc, seal_busy, !fifo_empty,
                    OFF_FIELD_W'(off_q)};
    end else if (data_rd) begin
      reg_rdata <= mode_q.rd ? mem_q : 16'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_status      <= '0;
      rx_payload_len <= '0;
      rx_bad         <= 1'b0;
    end else if (data_rd && mode_q.rd && mode_q.rx) begin
      if (off_q == OFF_W'(0)) begin
        rx_status <= mem_q;
        rx_bad    <= |(mem_q & ERR_MASK);
      end
      if (off_q == OFF_W'(2)) begin
        rx_payload_len <= mem_q[10:0] - RX_HDR_BYTES;
      end
    end
  end

endmodule

// File: rtl/pkt_data_port_chk.sv
module pkt_data_port_chk #(
  parameter int OFF_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       reg_sel,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             mode_rd,
  input logic             mode_rx,
  input logic             mode_ai,
  input logic [OFF_W-1:0] off_q,
  input logic             fifo_ne,
  input logic             seal_busy,
  input logic [10:0]      rx_payload_len
);

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (off_q == '0 && !mode_rd && !seal_busy && !fifo_ne));

  p_ptr_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 2'd0 && fifo_ne) |=> $stable({mode_rd, mode_rx, mode_ai}));

  p_ne_after_push_r4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 2'd1 && !mode_rd && !fifo_ne) |=> fifo_ne);

  p_rd_step_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel == 2'd1 && mode_rd && mode_ai && !reg_wr)
      |=> (off_q == OFF_W'($past(off_q) + OFF_W'(2))));

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_sel == 2'd1 && mode_rd && !mode_ai && !reg_wr) |=> $stable(off_q));

  p_wr_dropped_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 2'd1 && mode_rd) |=> !fifo_ne);

  p_len_on_read_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_payload_len) |-> $past(reg_rd));

endmodule

bind pkt_data_port pkt_data_port_chk #(.OFF_W(OFF_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .reg_sel        (reg_sel),
  .reg_wr         (reg_wr),
  .reg_rd         (reg_rd),
  .mode_rd        (mode_q.rd),
  .mode_rx        (mode_q.rx),
  .mode_ai        (mode_q.ainc),
  .off_q          (off_q),
  .fifo_ne        (!fifo_empty),
  .seal_busy      (seal_busy),
  .rx_payload_len (rx_payload_len)
);

// File: tb/pkt_data_port_tb.sv
`timescale 1ns/1ps
module pkt_data_port_tb;

  localparam logic [1:0] S_PTR  = 2'd0;
  localparam logic [1:0] S_DATA = 2'd1;
  localparam logic [1:0] S_SEAL = 2'd2;
  localparam int WATCHDOG = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_sel = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] rx_status;
  logic [10:0] rx_payload_len;
  logic        rx_bad;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 1'b0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_cap = 1'b0;

  always #10 clk = ~clk;

  pkt_data_port #(.AREA_BYTES(256), .FIFO_DEPTH(2), .ERR_MASK(16'hAC00)) u_dut (
    .clk            (clk),
    .rst            (rst),
    .reg_sel        (reg_sel),
    .reg_wr         (reg_wr),
    .reg_rd         (reg_rd),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .rx_status      (rx_status),
    .rx_payload_len (rx_payload_len),
    .rx_bad         (rx_bad)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // monitor: compares each registered read result against the scoreboard
  always @(posedge clk) rd_cap <= reg_rd && !rst;

  always @(negedge clk) begin
    if (rd_cap) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL scoreboard: got 0x%04h expected no read", reg_rdata);
      end else begin
        check(reg_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_wr(input logic [1:0] sel, input logic [15:0] d);
    reg_sel   = sel;
    reg_wdata = d;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_sel = sel;
    reg_rd  = 1'b1;
    @(negedge clk);
    reg_rd  = 1'b0;
  endtask

  function automatic logic [15:0] frame_word(input int i);
    return 16'((i * 257) + 3);
  endfunction

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    check(reg_rdata, 16'h0000, "R1 rdata after reset");
    check(rx_status, 16'h0000, "R1 rx_status after reset");
    check({5'd0, rx_payload_len}, 16'h0000, "R1 rx_payload_len after reset");
    check({15'd0, rx_bad}, 16'h0000, "R1 rx_bad after reset");
    do_rd(S_PTR, 16'h0000, "R1 pointer after reset");

    // R2 pointer layout and offset alignment
    do_wr(S_PTR, 16'hE010);
    idle(1);
    do_rd(S_PTR, 16'hE010, "R2 pointer readback");
    do_wr(S_PTR, 16'h2013);
    do_rd(S_PTR, 16'h2012, "R2 offset bit0 forced low");

    // R3/R4 write stream, pointer lock, not-empty flag
    do_wr(S_PTR, 16'h2020);
    do_wr(S_DATA, 16'h1111);
    do_wr(S_DATA, 16'h2222);
    do_wr(S_PTR, 16'h2080);
    do_rd(S_PTR, 16'h2024, "R4 pointer write ignored while FIFO busy");
    do_wr(S_DATA, 16'h3333);
    do_rd(S_PTR, 16'h2824, "R4 not-empty flag");
    do_rd(S_PTR, 16'h2026, "R3 write auto-increment");

    // R5 prefetched reads
    do_wr(S_PTR, 16'hA020);
    idle(1);
    do_rd(S_DATA, 16'h1111, "R5 first read");
    do_rd(S_DATA, 16'h2222, "R5 back-to-back read");
    do_rd(S_DATA, 16'h3333, "R5 third read");
    do_rd(S_PTR, 16'hA026, "R3 read auto-increment");
    do_wr(S_PTR, 16'h8022);
    idle(1);
    do_rd(S_DATA, 16'h2222, "R3 read without increment");
    do_rd(S_DATA, 16'h2222, "R3 repeated read same word");
    do_rd(S_PTR, 16'h8022, "R3 offset unchanged");

    // R11 write in read mode discarded
    do_wr(S_DATA, 16'hDEAD);
    idle(2);
    do_wr(S_PTR, 16'h8022);
    idle(1);
    do_rd(S_DATA, 16'h2222, "R11 write in read mode discarded");

    // Frame A: odd length 61
    do_wr(S_PTR, 16'h2004);
    for (int i = 0; i < 31; i++)
      do_wr(S_DATA, (i == 30) ? 16'hAB5C : frame_word(i));
    do_wr(S_SEAL, 16'd61);
    idle(12);
    do_wr(S_PTR, 16'hA000);
    idle(1);
    do_rd(S_DATA, 16'h0000, "R6 status word zero");
    do_rd(S_DATA, 16'd67, "R6 byte count odd frame");
    do_wr(S_PTR, 16'h803E);
    idle(1);
    do_rd(S_DATA, frame_word(29), "R6 data word kept");
    do_wr(S_PTR, 16'h8040);
    idle(1);
    do_rd(S_DATA, 16'h205C, "R8 odd control word");

    // Frame B: short length 7, padded to 60
    do_wr(S_PTR, 16'h2040);
    do_wr(S_DATA, 16'hFFFF);
    idle(2);
    do_wr(S_PTR, 16'h2004);
    for (int i = 0; i < 4; i++)
      do_wr(S_DATA, (i == 3) ? 16'h9977 : frame_word(i + 40));
    idle(2);
    do_wr(S_SEAL, 16'd7);
    do_rd(S_PTR, 16'h300C, "R12 seal busy flag set");
    idle(10);
    do_rd(S_PTR, 16'h200C, "R12 seal busy flag clear");
    do_wr(S_PTR, 16'hA000);
    idle(1);
    do_rd(S_DATA, 16'h0000, "R6 status word short frame");
    do_rd(S_DATA, 16'd66, "R7 padded byte count");
    do_wr(S_PTR, 16'h8040);
    idle(1);
    do_rd(S_DATA, 16'h0000, "R7 control word of padded frame");

    // Frame C: even length 100
    do_wr(S_PTR, 16'h2068);
    do_wr(S_DATA, 16'h5555);
    idle(2);
    do_wr(S_PTR, 16'h2004);
    for (int i = 0; i < 50; i++)
      do_wr(S_DATA, frame_word(i + 7));
    idle(2);
    do_wr(S_SEAL, 16'd100);
    idle(12);
    do_wr(S_PTR, 16'hA000);
    idle(1);
    do_rd(S_DATA, 16'h0000, "R6 status word even frame");
    do_rd(S_DATA, 16'd106, "R6 byte count even frame");
    do_wr(S_PTR, 16'h8068);
    idle(1);
    do_rd(S_DATA, 16'h0000, "R8 even control word");

    // Receive: clean frame with junk above the length field
    do_wr(S_PTR, 16'h6000);
    do_wr(S_DATA, 16'h0000);
    do_wr(S_DATA, 16'hF850);
    do_wr(S_DATA, 16'hCAFE);
    idle(2);
    do_wr(S_PTR, 16'hE000);
    idle(1);
    do_rd(S_DATA, 16'h0000, "R9 rx status word read");
    check({15'd0, rx_bad}, 16'h0000, "R9 rx_bad clear on good status");
    check(rx_status, 16'h0000, "R9 rx_status good");
    do_rd(S_DATA, 16'hF850, "R10 rx length word read");
    check({5'd0, rx_payload_len}, 16'd76, "R10 payload length masked");
    do_rd(S_DATA, 16'hCAFE, "R5 rx payload read");

    // Receive: error bit set
    do_wr(S_PTR, 16'h6000);
    do_wr(S_DATA, 16'h0410);
    do_wr(S_DATA, 16'h0044);
    idle(2);
    do_wr(S_PTR, 16'hE000);
    idle(1);
    do_rd(S_DATA, 16'h0410, "R9 rx error status read");
    check({15'd0, rx_bad}, 16'h0001, "R9 rx_bad set on error bit");
    check(rx_status, 16'h0410, "R9 rx_status error");
    do_rd(S_DATA, 16'h0044, "R10 rx length read");
    check({5'd0, rx_payload_len}, 16'd64, "R10 payload length of bad frame");

    idle(3);
    if (exp_q.size() != 0) begin
      n_checks++;
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule